// File: doc/BRIEF.md
# Debug Freeze Controller with Read-Side-Effect Gating

This block is the central point through which a debugger halts peripheral activity in a microcontroller subsystem. Software sets a single global halt bit and a per-peripheral enable mask. Each of eight peripherals (two 16-bit timers, two serial ports and four two-wire bus controllers) receives its own registered freeze line. A peripheral's line is high only when both the global bit and that peripheral's mask bit are set.

The block also owns a small bank of sticky status registers. Hardware events set their bits, and a read clears them. Each read also emits a one-cycle side-effect pulse. While the halt bit is set, ordinary core reads of these registers return the data but leave the register untouched and raise no pulse, so a debugger can look without disturbing anything. Three paths are exempt from this suppression:
- the NMI-style status register;
- core reads that travel over the cross-domain path into host-owned registers;
- every host-bus read.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: After a synchronous reset the halt bit, the enable mask, every status register, every freeze line, every side-effect pulse and both read-data outputs are 0.
- R2: A core write to address 0 stores `core_wdata[0]` as the halt bit, and a write to address 1 stores the 8-bit enable mask. A core read of address 0 returns the halt bit in bit 0 with zeros above it, and a read of address 1 returns the mask. Read data appears on `core_rdata` in the cycle after the read strobe.
- R3: `frz_out[k]` equals halt AND mask[k], one cycle after those registers change. Bits 0–1 are the timers, bits 2–3 the serial ports and bits 4–7 the bus controllers.
- R4: With halt at 0, a core read of status register i (address 2+i) returns its value in the next cycle and clears it at the clock edge that ends the read cycle. `rd_pulse[i]` is high for exactly the one cycle after the read.
- R5: With halt at 1, a core read over the direct path (`core_xdom`=0) of a status register other than register 0 returns the value but does not clear it and raises no pulse.
- R6: Status register 0 (the NMI status) clears and pulses on every core read, whatever the halt bit.
- R7: A core read with `core_xdom`=1 clears and pulses whatever the halt bit.
- R8: The host bus can read only status register 3 (address 5). That read returns the value on `host_rdata` in the next cycle, clears the register and pulses regardless of halt. A host read of any other address returns 0 and changes nothing.
- R9: When a hardware set and an unsuppressed read-clear reach the same status register in one cycle, the set bits end up 1 and all other bits end up 0.
- R10: Core writes to status-register addresses have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | 1 | Core bus access strobe |
| core_write | input | 1 | 1 = write, 0 = read |
| core_xdom | input | 1 | Access uses the core-to-host-domain path |
| core_addr | input | 4 | Core register address |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Core read data, registered |
| host_valid | input | 1 | Host bus read strobe |
| host_addr | input | 4 | Host register address |
| host_rdata | output | 8 | Host read data, registered |
| stat_set | input | 32 | Hardware set bits, 8 per status register, register i at [8i+7:8i] |
| frz_out | output | 8 | Per-peripheral freeze lines |
| rd_pulse | output | 4 | Per-status-register read side-effect pulse |

## Verification
The assertions assume that `core_valid` and `host_valid` are single-cycle strobes, and that each input is either held or changed only between clock edges. The properties about the value a register keeps after a read treat a simultaneous hardware set or host clear as part of the expected next value, so overlapping events do not break them. The bench drives every input on the falling edge and holds a strobe for exactly one cycle. It raises set bits only as separate one-cycle pulses, except in the one scenario that checks a set colliding with a clear.

// File: rtl/dbgfrz_pkg.sv
package dbgfrz_pkg;
  localparam int NUM_MODS  = 8;
  localparam int NUM_STAT  = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int STAT_BASE = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'd0,
    A_MASK = 4'd1
  } reg_addr_e;
endpackage

// File: rtl/dbgfrz_regs.sv
module dbgfrz_regs #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int NUM_MODS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_val,
  output logic                rd_hit,
  output logic                halt,
  output logic [NUM_MODS-1:0] frz_out
);
  import dbgfrz_pkg::*;

  logic                halt_q;
  logic [NUM_MODS-1:0] mask_q;
  logic [NUM_MODS-1:0] frz_q;
  logic                unused_wbits;

  assign unused_wbits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) halt_q <= wr_data[0];
      if (wr_addr == A_MASK) mask_q <= wr_data[NUM_MODS-1:0];
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_MODS; k++) begin : g_frz
      always_ff @(posedge clk) begin
        if (rst) frz_q[k] <= 1'b0;
        else     frz_q[k] <= halt_q & mask_q[k];
      end
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (rd_addr == A_CTRL) begin
      rd_val[0] = halt_q;
      rd_hit    = 1'b1;
    end else if (rd_addr == A_MASK) begin
      rd_val[NUM_MODS-1:0] = mask_q;
      rd_hit               = 1'b1;
    end
  end

  assign halt    = halt_q;
  assign frz_out = frz_q;

  a_r3_frz_needs_halt: assert property (@(posedge clk) disable iff (rst)
    (|frz_q) |-> $past(halt_q));
endmodule

// File: rtl/dbgfrz_stat_cell.sv
module dbgfrz_stat_cell #(
  parameter int W      = 8,
  parameter bit EXEMPT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         core_hit,
  input  logic         core_xdom,
  input  logic         host_hit,
  input  logic         halt,
  output logic [W-1:0] stat_q,
  output logic         pulse_q
);
  logic sup;
  logic clr;

  assign sup = core_hit & halt & ~EXEMPT & ~core_xdom;
  assign clr = (core_hit & ~sup) | host_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~{W{clr}}) | set_i;
      pulse_q <= clr;
    end
  end

  a_r4_pulse_src: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(core_hit || host_hit));
  a_r5_frozen_keep: assert property (@(posedge clk) disable iff (rst)
    (sup && !host_hit) |=> (stat_q == ($past(stat_q) | $past(set_i))) && !pulse_q);
  a_r6_nmi_clears: assert property (@(posedge clk) disable iff (rst)
    (EXEMPT && core_hit && set_i == '0) |=> stat_q == '0);
  a_r7_xdom_clears: assert property (@(posedge clk) disable iff (rst)
    (core_hit && core_xdom && set_i == '0) |=> stat_q == '0 && pulse_q);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> (stat_q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/dbgfrz_stat_bank.sv
module dbgfrz_stat_bank #(
  parameter int               W         = 8,
  parameter int               N         = 4,
  parameter int               ADDR_W    = 4,
  parameter int               BASE      = 2,
  parameter logic [N-1:0]     NMI_MASK  = 4'b0001,
  parameter logic [N-1:0]     HOST_MASK = 4'b1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic [N*W-1:0]    set_i,
  input  logic              core_rd,
  input  logic              core_xdom,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [W-1:0]      core_val,
  output logic              core_hit_any,
  output logic [W-1:0]      host_val,
  output logic [N-1:0]      pulse
);
  logic [N-1:0] c_hit;
  logic [N-1:0] h_hit;
  logic [W-1:0] stat [N];

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_cell
      assign c_hit[i] = core_rd && (core_addr == ADDR_W'(BASE + i));
      assign h_hit[i] = host_rd && HOST_MASK[i] && (host_addr == ADDR_W'(BASE + i));

      dbgfrz_stat_cell #(.W(W), .EXEMPT(NMI_MASK[i])) u_cell (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_i[i*W +: W]),
        .core_hit (c_hit[i]),
        .core_xdom(core_xdom),
        .host_hit (h_hit[i]),
        .halt     (halt),
        .stat_q   (stat[i]),
        .pulse_q  (pulse[i])
      );
    end
  endgenerate

  always_comb begin
    core_val = '0;
    host_val = '0;
    for (int j = 0; j < N; j++) begin
      if (c_hit[j]) core_val = stat[j];
      if (h_hit[j]) host_val = stat[j];
    end
  end

  assign core_hit_any = |c_hit;

  a_r8_host_scope: assert property (@(posedge clk) disable iff (rst)
    ((h_hit & ~HOST_MASK) == '0));
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl #(
  parameter int                               DATA_W    = dbgfrz_pkg::DATA_W,
  parameter int                               ADDR_W    = dbgfrz_pkg::ADDR_W,
  parameter int                               NUM_MODS  = dbgfrz_pkg::NUM_MODS,
  parameter int                               NUM_STAT  = dbgfrz_pkg::NUM_STAT,
  parameter logic [dbgfrz_pkg::NUM_STAT-1:0]  NMI_MASK  = 4'b0001,
  parameter logic [dbgfrz_pkg::NUM_STAT-1:0]  HOST_MASK = 4'b1000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       core_valid,
  input  logic                       core_write,
  input  logic                       core_xdom,
  input  logic [ADDR_W-1:0]          core_addr,
  input  logic [DATA_W-1:0]          core_wdata,
  output logic [DATA_W-1:0]          core_rdata,
  input  logic                       host_valid,
  input  logic [ADDR_W-1:0]          host_addr,
  output logic [DATA_W-1:0]          host_rdata,
  input  logic [NUM_STAT*DATA_W-1:0] stat_set,
  output logic [NUM_MODS-1:0]        frz_out,
  output logic [NUM_STAT-1:0]        rd_pulse
);
  localparam int BASE = dbgfrz_pkg::STAT_BASE;

  logic              halt;
  logic              core_rd;
  logic              core_wr;
  logic [DATA_W-1:0] reg_val;
  logic              reg_hit;
  logic [DATA_W-1:0] stat_cval;
  logic              stat_chit;
  logic [DATA_W-1:0] stat_hval;
  logic [DATA_W-1:0] core_rdata_q;
  logic [DATA_W-1:0] host_rdata_q;

  assign core_rd = core_valid & ~core_write;
  assign core_wr = core_valid &  core_write;

  dbgfrz_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MODS(NUM_MODS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (core_wr),
    .wr_addr(core_addr),
    .wr_data(core_wdata),
    .rd_addr(core_addr),
    .rd_val (reg_val),
    .rd_hit (reg_hit),
    .halt   (halt),
    .frz_out(frz_out)
  );

  dbgfrz_stat_bank #(
    .W(DATA_W), .N(NUM_STAT), .ADDR_W(ADDR_W), .BASE(BASE),
    .NMI_MASK(NMI_MASK), .HOST_MASK(HOST_MASK)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .halt        (halt),
    .set_i       (stat_set),
    .core_rd     (core_rd),
    .core_xdom   (core_xdom),
    .core_addr   (core_addr),
    .host_rd     (host_valid),
    .host_addr   (host_addr),
    .core_val    (stat_cval),
    .core_hit_any(stat_chit),
    .host_val    (stat_hval),
    .pulse       (rd_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rdata_q <= '0;
      host_rdata_q <= '0;
    end else begin
      if (core_rd) core_rdata_q <= reg_hit ? reg_val : (stat_chit ? stat_cval : '0);
      if (host_valid) host_rdata_q <= stat_hval;
    end
  end

  assign core_rdata = core_rdata_q;
  assign host_rdata = host_rdata_q;

  a_r3_halt_off: assert property (@(posedge clk) disable iff (rst)
    (core_wr && core_addr == ADDR_W'(0) && !core_wdata[0]) |=> ##1 frz_out == '0);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (frz_out == '0 && rd_pulse == '0 && core_rdata == '0));
endmodule

// File: tb/dbg_freeze_ctrl_test.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        core_valid, core_write, core_xdom;
  logic [3:0]  core_addr;
  logic [7:0]  core_wdata;
  logic [7:0]  core_rdata;
  logic        host_valid;
  logic [3:0]  host_addr;
  logic [7:0]  host_rdata;
  logic [31:0] stat_set;
  logic [7:0]  frz_out;
  logic [3:0]  rd_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dbg_freeze_ctrl uut (
    .clk(clk), .rst(rst), .core_valid(core_valid), .core_write(core_write),
    .core_xdom(core_xdom), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .host_valid(host_valid), .host_addr(host_addr),
    .host_rdata(host_rdata), .stat_set(stat_set), .frz_out(frz_out),
    .rd_pulse(rd_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    core_valid = 1; core_write = 1; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_valid = 0; core_write = 0;
  endtask

  task automatic cread(input logic [3:0] a, input logic x,
                       output logic [7:0] d, output logic [3:0] p);
    @(negedge clk);
    core_valid = 1; core_write = 0; core_addr = a; core_xdom = x;
    @(negedge clk);
    d = core_rdata; p = rd_pulse;
    core_valid = 0; core_xdom = 0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [7:0] d, output logic [3:0] p);
    @(negedge clk);
    host_valid = 1; host_addr = a;
    @(negedge clk);
    d = host_rdata; p = rd_pulse;
    host_valid = 0;
  endtask

  task automatic hwset(input int idx, input logic [7:0] v);
    @(negedge clk);
    stat_set = '0;
    stat_set[idx*8 +: 8] = v;
    @(negedge clk);
    stat_set = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [3:0] p;
    check("R1 frz_out", frz_out, 0);
    check("R1 rd_pulse", rd_pulse, 0);
    check("R1 core_rdata", core_rdata, 0);
    check("R1 host_rdata", host_rdata, 0);
    cread(4'd0, 0, d, p); check("R1 halt", d, 0);
    cread(4'd1, 0, d, p); check("R1 mask", d, 0);
    for (int i = 0; i < 4; i++) begin
      cread(4'(2+i), 0, d, p); check("R1 status", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] d; logic [3:0] p;
    cwrite(4'd1, 8'hA5);
    cread(4'd1, 0, d, p); check("R2 mask readback", d, 8'hA5);
    cwrite(4'd0, 8'hFF);
    cread(4'd0, 0, d, p); check("R2 halt readback", d, 8'h01);
    cwrite(4'd0, 8'h00);
    cread(4'd0, 0, d, p); check("R2 halt clear", d, 8'h00);
  endtask

  task automatic t_freeze_outs();
    cwrite(4'd1, 8'h3C);
    @(negedge clk); check("R3 halt off", frz_out, 8'h00);
    cwrite(4'd0, 8'h01);
    check("R3 not yet", frz_out, 8'h00);
    @(negedge clk); check("R3 masked freeze", frz_out, 8'h3C);
    cwrite(4'd1, 8'hC1);
    @(negedge clk); check("R3 new mask", frz_out, 8'hC1);
    cwrite(4'd0, 8'h00);
    @(negedge clk); check("R3 halt drop", frz_out, 8'h00);
    cwrite(4'd1, 8'h00);
  endtask

  task automatic t_read_clear();
    logic [7:0] d; logic [3:0] p;
    hwset(1, 8'h5A);
    cread(4'd3, 0, d, p);
    check("R4 read data", d, 8'h5A);
    check("R4 pulse", p, 4'b0010);
    @(negedge clk); check("R4 pulse one cycle", rd_pulse, 0);
    cread(4'd3, 0, d, p); check("R4 cleared", d, 0);
  endtask

  task automatic t_frozen();
    logic [7:0] d; logic [3:0] p;
    cwrite(4'd0, 8'h01);
    hwset(2, 8'h81);
    cread(4'd4, 0, d, p);
    check("R5 frozen data", d, 8'h81);
    check("R5 no pulse", p, 0);
    cread(4'd4, 0, d, p); check("R5 kept", d, 8'h81);
    cwrite(4'd0, 8'h00);
    cread(4'd4, 0, d, p); check("R5 unfrozen read", d, 8'h81);
    check("R5 unfrozen pulse", p, 4'b0100);
    cread(4'd4, 0, d, p); check("R5 now cleared", d, 0);
  endtask

  task automatic t_nmi();
    logic [7:0] d; logic [3:0] p;
    cwrite(4'd0, 8'h01);
    hwset(0, 8'h07);
    cread(4'd2, 0, d, p);
    check("R6 nmi data", d, 8'h07);
    check("R6 nmi pulse", p, 4'b0001);
    cread(4'd2, 0, d, p); check("R6 nmi cleared", d, 0);
    cwrite(4'd0, 8'h00);
  endtask

  task automatic t_xdom();
    logic [7:0] d; logic [3:0] p;
    cwrite(4'd0, 8'h01);
    hwset(3, 8'h3E);
    cread(4'd5, 0, d, p);
    check("R5 host reg direct frozen", p, 0);
    cread(4'd5, 1, d, p);
    check("R7 xdom data", d, 8'h3E);
    check("R7 xdom pulse", p, 4'b1000);
    cread(4'd5, 0, d, p); check("R7 xdom cleared", d, 0);
    cwrite(4'd0, 8'h00);
  endtask

  task automatic t_host();
    logic [7:0] d; logic [3:0] p;
    cwrite(4'd0, 8'h01);
    hwset(3, 8'h44);
    hread(4'd5, d, p);
    check("R8 host data", d, 8'h44);
    check("R8 host pulse", p, 4'b1000);
    hread(4'd5, d, p); check("R8 host cleared", d, 0);
    hwset(1, 8'h12);
    hread(4'd3, d, p);
    check("R8 out of scope data", d, 0);
    check("R8 out of scope pulse", p, 0);
    cwrite(4'd0, 8'h00);
    cread(4'd3, 0, d, p); check("R8 untouched", d, 8'h12);
  endtask

  task automatic t_set_wins();
    logic [7:0] d; logic [3:0] p;
    hwset(1, 8'hF0);
    @(negedge clk);
    core_valid = 1; core_write = 0; core_addr = 4'd3; core_xdom = 0;
    stat_set = 32'h0000_0300;
    @(negedge clk);
    core_valid = 0; stat_set = '0;
    check("R9 old data", core_rdata, 8'hF0);
    cread(4'd3, 0, d, p); check("R9 set wins", d, 8'h03);
  endtask

  task automatic t_write_ignore();
    logic [7:0] d; logic [3:0] p;
    hwset(2, 8'h18);
    cwrite(4'd4, 8'hFF);
    cwrite(4'd2, 8'hFF);
    cread(4'd4, 0, d, p); check("R10 status write ignored", d, 8'h18);
    cread(4'd2, 0, d, p); check("R10 nmi write ignored", d, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; core_valid = 0; core_write = 0; core_xdom = 0;
    core_addr = 0; core_wdata = 0; host_valid = 0; host_addr = 0; stat_set = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_freeze_outs();
    t_read_clear();
    t_frozen();
    t_nmi();
    t_xdom();
    t_host();
    t_set_wins();
    t_write_ignore();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule